// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block synchronises a fixed group of participants (`NUM_PART` of them) at a barrier that can be reused without pause. Each participant owns one private sense bit. When a participant arrives, its sense bit flips. A shared arrival counter then adds the arrival. The arrival that brings the count to `NUM_PART` clears the counter and flips a single global flag. That flip publishes the episode's new sense to the whole group. A participant may proceed whenever its private sense equals the global flag, and `release_o` shows this comparison.

Because the sense alternates from one episode to the next, the flag never has to be cleared between episodes. A participant that leaves one episode and arrives again straight away is counted in the next episode. It cannot be confused with a late leaver from the previous one. Arrivals that land in the same cycle are all accepted in that cycle, using a population count. An arrival pulse from a participant that is still waiting is ignored.

Top module: `sense_barrier`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, `flag_o` is 0, every bit of `sense_o` is 0, and every bit of `release_o` is 1.
- R2: An accepted arrival on bit i of `arrive_i` inverts `sense_o[i]` at the next clock edge. An arrival is accepted when `release_o[i]` is 1 in that cycle.
- R3: `release_o[i]` is 1 exactly when `sense_o[i]` equals `flag_o`. A bit of `release_o` only falls in the cycle after an accepted arrival on that bit.
- R4: An arrival on bit i while `release_o[i]` is 0 is ignored. `sense_o[i]` does not change and the pulse adds nothing to `count_o`.
- R5: All arrivals accepted in one cycle are counted in that cycle. `count_o` grows by the number of accepted arrivals, unless the episode completes.
- R6: When the accepted arrivals bring the count to `NUM_PART`, the next edge sets `count_o` to 0 and inverts `flag_o`. After that edge every bit of `release_o` is 1.
- R7: Episodes run back to back with alternating sense and no flag clear. An arrival in the cycle right after a completion is counted toward the new episode.
- R8: `count_o` never reaches `NUM_PART`; it stays in the range 0 to `NUM_PART`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_i | input | NUM_PART | One-cycle arrival pulse per participant |
| release_o | output | NUM_PART | High when the participant may proceed (private sense equals global flag) |
| sense_o | output | NUM_PART | Private sense bit of each participant |
| flag_o | output | 1 | Global flag published by the completing arrival |
| count_o | output | $clog2(NUM_PART+1) | Arrivals counted in the current episode |

## Verification
The bench aims at the following corner cases:
- All participants arriving in one cycle. A design that serialised arrivals or dropped one would never complete, or would complete one episode late.
- Repeated pulses from participants that are already waiting, mixed with fresh arrivals in the same cycle. A design that counted these pulses would release the group early and flip the waiting participant's sense the wrong way.
- Re-arrival in the cycle right after a completion, over many alternating episodes. A design that needed a flag clear, or that kept stale counts, would deadlock or release the wrong group.
- Long pseudo-random arrival streams, compared against the bench's behavioural model on every clock.

// File: rtl/barrier_pkg.sv
`timescale 1ns/1ps
// Package barrier_pkg
// Shared sizing helpers for the sense-reversing barrier.
// Assumes at least one participant.
package barrier_pkg;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sense_cell.sv
`timescale 1ns/1ps
// Module sense_cell
// Holds one participant's private sense bit. An arrival is accepted only
// while the participant is released (sense equals the global flag). An
// accepted arrival inverts the sense. Assumes the flag changes only at
// episode completion.
module sense_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic glob_flag,
    output logic sense,
    output logic accept
);

    logic sense_q;

    // Accept only when the participant is not waiting in the current episode.
    always_comb accept = arrive & (sense_q == glob_flag);

    // Flip the private sense on every accepted arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)      sense_q <= 1'b0;
        else if (accept) sense_q <= ~sense_q;
    end

    assign sense = sense_q;

endmodule

// File: rtl/arrival_counter.sv
`timescale 1ns/1ps
// Module arrival_counter
// Counts accepted arrivals in the current episode. Any number of arrivals
// may land in one cycle; they are added with a population count. Signals
// completion when the running total reaches NUM_PART and then wraps to zero.
// Assumes each participant is accepted at most once per episode.
module arrival_counter #(
    parameter int NUM_PART = 4,
    parameter int CW       = barrier_pkg::cnt_width(NUM_PART)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] accept_vec,
    output logic [CW-1:0]       count,
    output logic                complete
);

    localparam int SW = CW + 1;

    logic [CW-1:0] count_q;
    logic [CW-1:0] pop;
    logic [SW-1:0] total;

    // Population count of this cycle's accepted arrivals.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_PART; i++) pop = pop + CW'(accept_vec[i]);
    end

    // Running total including this cycle and the completion test.
    always_comb begin
        total    = SW'(count_q) + SW'(pop);
        complete = (total == SW'(NUM_PART));
    end

    // Register the count; the completing arrival resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (complete) count_q <= '0;
        else               count_q <= total[CW-1:0];
    end

    assign count = count_q;

endmodule

// File: rtl/sense_barrier.sv
`timescale 1ns/1ps
// Module sense_barrier
// Centralised sense-reversing barrier for NUM_PART participants. Each
// participant has its own sense cell, and one shared counter accepts every
// arrival of a cycle together. The global flag inverts when an episode
// completes, so it never needs clearing between episodes. Assumes arrive_i
// pulses come from participants that later watch release_o.
module sense_barrier #(
    parameter int NUM_PART = 4,
    parameter int CW       = barrier_pkg::cnt_width(NUM_PART)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] arrive_i,
    output logic [NUM_PART-1:0] release_o,
    output logic [NUM_PART-1:0] sense_o,
    output logic                flag_o,
    output logic [CW-1:0]       count_o
);

    logic [NUM_PART-1:0] accept_vec;
    logic                complete;
    logic                flag_q;

    // One sense cell per participant.
    for (genvar g = 0; g < NUM_PART; g++) begin : g_cell
        sense_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .arrive    (arrive_i[g]),
            .glob_flag (flag_q),
            .sense     (sense_o[g]),
            .accept    (accept_vec[g])
        );
    end

    arrival_counter #(.NUM_PART(NUM_PART), .CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_vec (accept_vec),
        .count      (count_o),
        .complete   (complete)
    );

    // Publish the episode's new sense when the last arrival is counted.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (complete) flag_q <= ~flag_q;
    end

    // A participant proceeds when its sense matches the published flag.
    always_comb release_o = ~(sense_o ^ {NUM_PART{flag_q}});

    assign flag_o = flag_q;

endmodule

// File: rtl/sense_barrier_chk.sv
`timescale 1ns/1ps
// Module sense_barrier_chk
// Property checker for sense_barrier, attached with bind. It watches only
// the top-level ports.
module sense_barrier_chk #(
    parameter int NUM_PART = 4,
    parameter int CW       = barrier_pkg::cnt_width(NUM_PART)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PART-1:0] arrive_i,
    input logic [NUM_PART-1:0] release_o,
    input logic [NUM_PART-1:0] sense_o,
    input logic                flag_o,
    input logic [CW-1:0]       count_o
);

    // R8: the count stays below the group size.
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_o) < NUM_PART);

    // R2: an accepted arrival flips that participant's sense.
    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_o ^ $past(sense_o)) == ($past(arrive_i) & $past(release_o))));

    // R4: a waiting participant's pulse never changes its sense.
    p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((sense_o ^ $past(sense_o)) & ~$past(release_o)) == '0));

    // R3: release only falls after an arrival on that bit.
    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~release_o & $past(release_o) & ~$past(arrive_i)) == '0));

    // R6: the flag moves only with a counter wrap and a full release.
    p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_o) |-> (count_o == '0) && (&release_o));

    // R5: the count grows by the accepted arrivals unless it wraps.
    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) ||
        (int'(count_o) == int'($past(count_o)) + $countones($past(arrive_i & release_o))));

endmodule

bind sense_barrier sense_barrier_chk #(.NUM_PART(NUM_PART), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive_i),
    .release_o (release_o),
    .sense_o   (sense_o),
    .flag_o    (flag_o),
    .count_o   (count_o)
);

// File: tb/test_sense_barrier.sv
`timescale 1ns/1ps
module test_sense_barrier;

    localparam int P  = 4;
    localparam int CW = $clog2(P + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [P-1:0]  arrive;
    logic [P-1:0]  release_w;
    logic [P-1:0]  sense_w;
    logic          flag_w;
    logic [CW-1:0] count_w;

    // Behavioural model state.
    logic [P-1:0]  m_sense;
    logic          m_flag;
    int            m_count;
    int            n_vec;
    int            n_bad;
    bit            finished;
    logic [15:0]   lfsr;

    always #10 clk = ~clk;

    sense_barrier #(.NUM_PART(P)) i_sense_barrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (release_w),
        .sense_o   (sense_w),
        .flag_o    (flag_w),
        .count_o   (count_w)
    );

    task automatic compare(input string tag);
        logic [P-1:0] exp_rel;
        exp_rel = ~(m_sense ^ {P{m_flag}});
        n_vec++;
        if (sense_w !== m_sense || flag_w !== m_flag ||
            count_w !== CW'(m_count) || release_w !== exp_rel) begin
            n_bad++;
            $display("FAIL %s: sense=%b flag=%b count=%0d release=%b expected sense=%b flag=%b count=%0d release=%b",
                     tag, sense_w, flag_w, count_w, release_w, m_sense, m_flag, m_count, exp_rel);
        end
    endtask

    // Apply one cycle of arrivals, advance the model, compare after the edge.
    task automatic step(input logic [P-1:0] a, input string tag);
        logic [P-1:0] acc;
        int pop;
        @(negedge clk);
        arrive = a;
        @(posedge clk);
        acc = a & ~(m_sense ^ {P{m_flag}});
        pop = $countones(acc);
        m_sense = m_sense ^ acc;
        if (m_count + pop == P) begin
            m_count = 0;
            m_flag  = ~m_flag;
        end else begin
            m_count = m_count + pop;
        end
        #5;
        compare(tag);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(20 * 60000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        n_vec = 0; n_bad = 0; finished = 0;
        arrive = '0; rst_n = 1'b0;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_sense = '0; m_flag = 1'b0; m_count = 0;
        compare("R1 reset state");

        // Single arrivals, with a repeated pulse from a waiting participant.
        step(4'b0001, "R2 first arrival flips sense");
        step(4'b0000, "R3 waiting participant held");
        step(4'b0001, "R4 repeat from waiting ignored");
        step(4'b0010, "R2 second arrival");
        step(4'b0100, "R5 third arrival counted");
        step(4'b0111, "R4 all waiting pulses ignored");
        step(4'b1000, "R6 last arrival completes");
        step(4'b0000, "R6 all released, count zero");

        // Everyone at once, then immediately again.
        step(4'b1111, "R5 simultaneous full arrival");
        step(4'b1111, "R7 back-to-back episode");
        step(4'b0000, "R7 idle");

        // Split arrivals with a mix of new and repeated pulses.
        step(4'b0011, "R5 two at once");
        step(4'b0111, "R4 mix of repeat and new");
        step(4'b1000, "R6 completes on fourth");
        step(4'b1001, "R7 re-arrival right after completion");
        step(4'b0110, "R6 second half completes");
        step(4'b0000, "R3 idle after release");

        // Pseudo-random streams compared every cycle.
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[P-1:0] & lfsr[P+3:4] | lfsr[P+7:8] & {P{lfsr[15]}}, "R8 random stream");
        end
        step(4'b0000, "R8 final idle");

        finished = 1;
        summary();
        $finish;
    end

endmodule